// File: doc/BRIEF.md
# Subcarrier Permutation Address Generator

This block places each incoming complex frequency-domain sample straight into its permuted slot within an OFDM symbol. Every sample arrives with three indices: its position inside a subchannel (`k`, 0 to 23), its subchannel number inside a major group (`s`), and the major group it belongs to (0 to 5). A short pipeline turns these indices into a memory address. The data travels alongside the address, so the symbol memory ends up holding the permuted symbol. No separate reordering pass is needed.

The memory is double buffered. After all 1440 positions of a symbol have been written, the block streams that symbol out in ascending position order, one sample per clock. At the same time it fills the other buffer with the next symbol. The two per-length permutation tables are parameters. Pilot, DC and guard insertion belong to a later stage.

Top module: `subcarrier_perm_addrgen`

## Requirements
- R1: The block computes the rotated subcarrier index as r = (k + 13*s) mod 24. The in-group offset is N*r + T[(s + r) mod N], where N is the subchannel count of the group and T is the matching permutation table.
- R2: A group with an even index uses N = 12 and the 12-entry table. A group with an odd index uses N = 8 and the 8-entry table. With the default tables the 12-entry table is {3,7,0,10,5,1,9,11,2,6,4,8} and the 8-entry table is {5,2,7,0,3,6,1,4}.
- R3: Group g starts at position (g div 2)*480, plus 288 when g is odd. Every address stays below 1440. Within one symbol each position is written exactly once.
- R4: A sample accepted on a clock edge appears on `wr_addr`/`wr_data` with `wr_valid` high after the next edge. Its data is unchanged.
- R5: `wr_bank` is 0 for the first symbol after reset and toggles after every 1440th write.
- R6: The first read-out sample becomes valid on the third clock edge after the edge that accepts a symbol's final sample. `out_pos` then counts 0 to 1439 on consecutive cycles, and `out_valid` falls after the last position when no further symbol has completed.
- R7: The value read out at position p is the data of the sample whose computed address was p.
- R8: Writing of the next symbol proceeds while the previous symbol is being read out, including input at one sample per clock with no gap between symbols.
- R9: After reset, `wr_valid` and `out_valid` are low.
- R10: A cycle with `in_valid` low causes no write, whatever the index and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_k | input | 5 | Subcarrier index inside the subchannel |
| in_s | input | 4 | Subchannel index inside the major group |
| in_grp | input | 3 | Major group index |
| in_data | input | 32 | Complex sample (I and Q) |
| wr_valid | output | 1 | Memory write strobe |
| wr_bank | output | 1 | Buffer currently being written |
| wr_addr | output | 11 | Computed position within the symbol |
| wr_data | output | 32 | Sample being written |
| out_valid | output | 1 | Read-out sample present |
| out_pos | output | 11 | Position of the read-out sample |
| out_data | output | 32 | Read-out sample |

## Verification
The assertions assume that valid inputs stay in range: `k` below 24, `s` below the group's subchannel count, and the group index below 6. They also assume that each (group, subchannel, subcarrier) triple arrives exactly once per symbol, and that samples arrive no faster than one per clock. The stimulus meets these assumptions by building, for every symbol, the full list of 1440 triples. The list is sent in natural order, in reverse order, or as a seeded random shuffle, with or without idle cycles. During idle cycles the bench deliberately puts out-of-range junk on the index inputs while valid is low.

// File: rtl/perm_pkg.sv
package perm_pkg;
    localparam int unsigned SC_PER_SUBCH = 24;
    localparam int unsigned SUBCH_STRIDE = 13;
    localparam int unsigned MOD_STEPS    = 8;

    // Modulo by repeated compare-and-subtract; valid while x < (MOD_STEPS+1)*m.
    function automatic int unsigned mod_reduce(int unsigned x, int unsigned m);
        int unsigned r;
        r = x;
        for (int i = 0; i < int'(MOD_STEPS); i++) begin
            if (r >= m) r = r - m;
        end
        return r;
    endfunction
endpackage

// File: rtl/perm_addr_calc.sv
module perm_addr_calc
    import perm_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NUM_GROUPS = 6,
    parameter int unsigned N_EVEN     = 12,
    parameter int unsigned N_ODD      = 8,
    parameter int unsigned PB_EVEN [N_EVEN] = '{3, 7, 0, 10, 5, 1, 9, 11, 2, 6, 4, 8},
    parameter int unsigned PB_ODD  [N_ODD]  = '{5, 2, 7, 0, 3, 6, 1, 4},
    localparam int unsigned SPAN_EVEN = N_EVEN * SC_PER_SUBCH,
    localparam int unsigned SPAN_ODD  = N_ODD * SC_PER_SUBCH,
    localparam int unsigned PAIR_SPAN = SPAN_EVEN + SPAN_ODD,
    localparam int unsigned SYM_LEN   = (NUM_GROUPS / 2) * PAIR_SPAN + (NUM_GROUPS % 2) * SPAN_EVEN,
    localparam int unsigned ADDR_W    = $clog2(SYM_LEN),
    localparam int unsigned K_W       = $clog2(SC_PER_SUBCH),
    localparam int unsigned S_W       = $clog2(N_EVEN),
    localparam int unsigned G_W       = $clog2(NUM_GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [K_W-1:0]    in_k,
    input  logic [S_W-1:0]    in_s,
    input  logic [G_W-1:0]    in_grp,
    input  logic [DATA_W-1:0] in_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int unsigned PBE_IW = $clog2(N_EVEN);
    localparam int unsigned PBO_IW = $clog2(N_ODD);

    typedef struct packed {
        logic              v;
        logic              odd;
        logic [S_W-1:0]    s;
        logic [K_W-1:0]    nk;
        logic [ADDR_W-1:0] base;
        logic [DATA_W-1:0] data;
    } stage1_t;

    typedef struct packed {
        logic              v;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } stage2_t;

    typedef struct packed {
        stage1_t st1;
        stage2_t st2;
    } calc_state_t;

    calc_state_t state_d, state_q;

    always_comb begin
        int unsigned rot_d, nk_d, base_d, nsch_d, col_d, pb_d, addr_d;
        state_d = state_q;
        // stage 1: rotated subcarrier index and group base
        rot_d  = mod_reduce(SUBCH_STRIDE * int'(in_s), SC_PER_SUBCH);
        nk_d   = mod_reduce(int'(in_k) + rot_d, SC_PER_SUBCH);
        base_d = int'(in_grp >> 1) * PAIR_SPAN + (in_grp[0] ? SPAN_EVEN : 0);
        state_d.st1.v    = in_valid;
        state_d.st1.odd  = in_grp[0];
        state_d.st1.s    = in_s;
        state_d.st1.nk   = K_W'(nk_d);
        state_d.st1.base = ADDR_W'(base_d);
        state_d.st1.data = in_data;
        // stage 2: table lookup and final address
        nsch_d = state_q.st1.odd ? N_ODD : N_EVEN;
        col_d  = mod_reduce(int'(state_q.st1.s) + int'(state_q.st1.nk), nsch_d);
        pb_d   = state_q.st1.odd ? PB_ODD[PBO_IW'(col_d)] : PB_EVEN[PBE_IW'(col_d)];
        addr_d = int'(state_q.st1.base) + nsch_d * int'(state_q.st1.nk) + pb_d;
        state_d.st2.v    = state_q.st1.v;
        state_d.st2.addr = ADDR_W'(addr_d);
        state_d.st2.data = state_q.st1.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign wr_valid = state_q.st2.v;
    assign wr_addr  = state_q.st2.addr;
    assign wr_data  = state_q.st2.data;

    // Input indices in range (precondition of R1)
    assert_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (int'(in_k) < SC_PER_SUBCH) && (int'(in_grp) < NUM_GROUPS)
                     && (int'(in_s) < (in_grp[0] ? N_ODD : N_EVEN)));

    assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> int'(wr_addr) < SYM_LEN);

    assert_wr_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 wr_valid);
endmodule

// File: rtl/sym_buffer.sv
module sym_buffer #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned SYM_LEN = 1440,
    localparam int unsigned ADDR_W = $clog2(SYM_LEN),
    localparam int unsigned MEM_W  = $clog2(2 * SYM_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_bank,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_pos,
    output logic [DATA_W-1:0] out_data
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(SYM_LEN - 1);

    typedef struct packed {
        logic              wbank;
        logic [ADDR_W-1:0] wcnt;
        logic              rbank;
        logic              ractive;
        logic [ADDR_W-1:0] rpos;
        logic              ov;
        logic [ADDR_W-1:0] opos;
    } buf_state_t;

    buf_state_t state_d, state_q;
    logic [DATA_W-1:0] mem [2*SYM_LEN];
    logic [DATA_W-1:0] rdata_q;
    logic [SYM_LEN-1:0] seen_q;
    logic [MEM_W-1:0] widx, ridx;

    assign widx = state_q.wbank ? MEM_W'(wr_addr) + MEM_W'(SYM_LEN) : MEM_W'(wr_addr);
    assign ridx = state_q.rbank ? MEM_W'(state_q.rpos) + MEM_W'(SYM_LEN) : MEM_W'(state_q.rpos);

    always_comb begin
        state_d    = state_q;
        state_d.ov = 1'b0;
        if (state_q.ractive) begin
            state_d.ov   = 1'b1;
            state_d.opos = state_q.rpos;
            if (state_q.rpos == LAST) state_d.ractive = 1'b0;
            else                      state_d.rpos    = state_q.rpos + 1'b1;
        end
        if (wr_valid) begin
            if (state_q.wcnt == LAST) begin
                state_d.wcnt    = '0;
                state_d.wbank   = ~state_q.wbank;
                state_d.rbank   = state_q.wbank;
                state_d.ractive = 1'b1;
                state_d.rpos    = '0;
            end else begin
                state_d.wcnt = state_q.wcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (wr_valid)        mem[widx] <= wr_data;
        if (state_q.ractive) rdata_q   <= mem[ridx];
    end

    // occupancy map of the symbol being written, for the duplicate check
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= '0;
        else if (wr_valid) begin
            if (state_q.wcnt == LAST) seen_q <= '0;
            else                      seen_q[wr_addr] <= 1'b1;
        end
    end

    assign wr_bank   = state_q.wbank;
    assign out_valid = state_q.ov;
    assign out_pos   = state_q.opos;
    assign out_data  = rdata_q;

    assert_no_dup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !seen_q[wr_addr]);

    assert_pos_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pos != '0) |-> $past(out_valid) && (out_pos == $past(out_pos) + 1'b1));

    assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pos != LAST) |=> out_valid);

    assert_bank_split_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ractive && wr_valid) |-> (wr_bank != state_q.rbank));
endmodule

// File: rtl/subcarrier_perm_addrgen.sv
module subcarrier_perm_addrgen
    import perm_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NUM_GROUPS = 6,
    parameter int unsigned N_EVEN     = 12,
    parameter int unsigned N_ODD      = 8,
    parameter int unsigned PB_EVEN [N_EVEN] = '{3, 7, 0, 10, 5, 1, 9, 11, 2, 6, 4, 8},
    parameter int unsigned PB_ODD  [N_ODD]  = '{5, 2, 7, 0, 3, 6, 1, 4},
    localparam int unsigned SYM_LEN = (NUM_GROUPS / 2) * (N_EVEN + N_ODD) * SC_PER_SUBCH
                                    + (NUM_GROUPS % 2) * N_EVEN * SC_PER_SUBCH,
    localparam int unsigned ADDR_W  = $clog2(SYM_LEN),
    localparam int unsigned K_W     = $clog2(SC_PER_SUBCH),
    localparam int unsigned S_W     = $clog2(N_EVEN),
    localparam int unsigned G_W     = $clog2(NUM_GROUPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [K_W-1:0]    in_k,
    input  logic [S_W-1:0]    in_s,
    input  logic [G_W-1:0]    in_grp,
    input  logic [DATA_W-1:0] in_data,
    output logic              wr_valid,
    output logic              wr_bank,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_pos,
    output logic [DATA_W-1:0] out_data
);
    perm_addr_calc #(
        .DATA_W(DATA_W), .NUM_GROUPS(NUM_GROUPS), .N_EVEN(N_EVEN), .N_ODD(N_ODD),
        .PB_EVEN(PB_EVEN), .PB_ODD(PB_ODD)
    ) u_calc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_k(in_k), .in_s(in_s),
        .in_grp(in_grp), .in_data(in_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    sym_buffer #(.DATA_W(DATA_W), .SYM_LEN(SYM_LEN)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_bank(wr_bank), .out_valid(out_valid), .out_pos(out_pos), .out_data(out_data)
    );
endmodule

// File: tb/tb_subcarrier_perm_addrgen.sv
`timescale 1ns/1ps
module tb_subcarrier_perm_addrgen;
    localparam int SYM = 1440;
    localparam int NSYM = 5;
    localparam int T12 [12] = '{3, 7, 0, 10, 5, 1, 9, 11, 2, 6, 4, 8};
    localparam int T8  [8]  = '{5, 2, 7, 0, 3, 6, 1, 4};

    logic clk = 0, rst_n = 0;
    logic in_valid = 0;
    logic [4:0] in_k = 0;
    logic [3:0] in_s = 0;
    logic [2:0] in_grp = 0;
    logic [31:0] in_data = 0;
    logic wr_valid, wr_bank, out_valid;
    logic [10:0] wr_addr, out_pos;
    logic [31:0] wr_data, out_data;

    subcarrier_perm_addrgen dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_k(in_k), .in_s(in_s),
        .in_grp(in_grp), .in_data(in_data), .wr_valid(wr_valid), .wr_bank(wr_bank),
        .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(out_valid), .out_pos(out_pos),
        .out_data(out_data)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    function automatic int exp_addr(int k, int s, int g);
        int n, r, pb;
        n  = (g % 2) ? 8 : 12;
        r  = (k + 13 * s) % 24;
        pb = (g % 2) ? T8[(s + r) % n] : T12[(s + r) % n];
        return (g / 2) * 480 + ((g % 2) ? 288 : 0) + n * r + pb;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // bench reference state
    logic [31:0] exp_mem [3][SYM];
    int last_acc [3];
    bit p_v = 0; int p_addr = 0; logic [31:0] p_data = 0;
    int acc_cnt = 0, acc_sym = 0, wr_cnt = 0, wr_sym = 0, rd_cnt = 0, rd_sym = 0;

    // sampler: 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        cyc++;
        if (rst_n) begin
            // R4 / R1 / R2 / R3 / R10: write port follows accepted sample by one edge
            if (p_v) begin
                chk(wr_valid === 1'b1, "R4 wr_valid", int'(wr_valid), 1);
                chk(int'(wr_addr) == p_addr, "R1 R2 R3 wr_addr", int'(wr_addr), p_addr);
                chk(wr_data === p_data, "R4 wr_data", int'(wr_data), int'(p_data));
                chk(int'(wr_bank) == wr_sym % 2, "R5 wr_bank", int'(wr_bank), wr_sym % 2);
                wr_cnt++;
                if (wr_cnt == SYM) begin wr_cnt = 0; wr_sym++; end
            end else begin
                chk(wr_valid === 1'b0, "R10 no write on idle", int'(wr_valid), 0);
            end
            // R6 / R7 / R8: read-out stream
            if (out_valid) begin
                if (rd_cnt == 0)
                    chk(cyc - last_acc[rd_sym % 3] == 3, "R6 first-out latency",
                        cyc - last_acc[rd_sym % 3], 3);
                chk(int'(out_pos) == rd_cnt, "R6 out_pos", int'(out_pos), rd_cnt);
                chk(out_data === exp_mem[rd_sym % 3][rd_cnt], "R7 R8 out_data",
                    int'(out_data), int'(exp_mem[rd_sym % 3][rd_cnt]));
                rd_cnt++;
                if (rd_cnt == SYM) begin rd_cnt = 0; rd_sym++; end
            end
            // record what this edge accepted
            p_v = in_valid;
            if (in_valid) begin
                p_addr = exp_addr(int'(in_k), int'(in_s), int'(in_grp));
                p_data = in_data;
                exp_mem[acc_sym % 3][p_addr] = in_data;
                acc_cnt++;
                if (acc_cnt == SYM) begin
                    last_acc[acc_sym % 3] = cyc;
                    acc_cnt = 0;
                    acc_sym++;
                end
            end
        end
        if (cyc > 60000 && !done) begin
            chk(0, "watchdog", cyc, 60000);
            finish_run();
        end
    end

    int ok_k [SYM], ok_s [SYM], ok_g [SYM];

    task automatic build_order(int mode);
        int i = 0;
        for (int g = 0; g < 6; g++)
            for (int s = 0; s < ((g % 2) ? 8 : 12); s++)
                for (int k = 0; k < 24; k++) begin
                    ok_k[i] = k; ok_s[i] = s; ok_g[i] = g; i++;
                end
        if (mode == 2) begin
            for (int j = 0; j < SYM / 2; j++) begin
                int t;
                t = ok_k[j]; ok_k[j] = ok_k[SYM-1-j]; ok_k[SYM-1-j] = t;
                t = ok_s[j]; ok_s[j] = ok_s[SYM-1-j]; ok_s[SYM-1-j] = t;
                t = ok_g[j]; ok_g[j] = ok_g[SYM-1-j]; ok_g[SYM-1-j] = t;
            end
        end else if (mode != 0) begin
            for (int j = SYM - 1; j > 0; j--) begin
                int r, t;
                r = int'($urandom % (j + 1));
                t = ok_k[j]; ok_k[j] = ok_k[r]; ok_k[r] = t;
                t = ok_s[j]; ok_s[j] = ok_s[r]; ok_s[r] = t;
                t = ok_g[j]; ok_g[j] = ok_g[r]; ok_g[r] = t;
            end
        end
    endtask

    // mode 0 natural, 1 shuffled with idle gaps, 2 reverse, 3 shuffled
    task automatic send_symbol(int mode);
        build_order(mode);
        for (int i = 0; i < SYM; i++) begin
            if (mode == 1 && ($urandom % 4) == 0) begin
                @(negedge clk);
                in_valid = 0;
                in_k = 5'($urandom); in_s = 4'($urandom);
                in_grp = 3'($urandom); in_data = $urandom;
            end
            @(negedge clk);
            in_valid = 1;
            in_k = 5'(ok_k[i]); in_s = 4'(ok_s[i]); in_grp = 3'(ok_g[i]);
            in_data = $urandom;
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(wr_valid === 1'b0, "R9 reset wr_valid", int'(wr_valid), 0);
        chk(out_valid === 1'b0, "R9 reset out_valid", int'(out_valid), 0);
        rst_n = 1;
        @(negedge clk);
        chk(wr_valid === 1'b0 && out_valid === 1'b0, "R9 idle after reset", int'(out_valid), 0);
        // spot checks of the bench formula's group bases (R3)
        chk(exp_addr(0, 0, 1) >= 288 && exp_addr(0, 0, 1) < 480, "R3 odd group base", exp_addr(0, 0, 1), 288);
        chk(exp_addr(23, 7, 5) >= 1248 && exp_addr(23, 7, 5) < SYM, "R3 last group span", exp_addr(23, 7, 5), 1248);
        send_symbol(0);
        send_symbol(1);
        send_symbol(2);   // back-to-back full rate (R8)
        send_symbol(3);
        send_symbol(1);
        @(negedge clk);
        in_valid = 0;
        repeat (SYM + 20) @(negedge clk);
        chk(rd_sym == NSYM, "R6 R7 all symbols read out", rd_sym, NSYM);
        chk(out_valid === 1'b0, "R6 out_valid falls after last symbol", int'(out_valid), 0);
        chk(wr_sym == NSYM, "R5 write count", wr_sym, NSYM);
        finish_run();
    end
endmodule